// File: doc/BRIEF.md
# Load-Align Shift Accumulator

This block holds a 64-bit destination value that is assembled from a stream of narrow memory reads. Each accepted load command carries an already formed byte address and a size bit that selects a byte or a halfword access. The block issues one read on a synchronous, byte-addressed memory port. When the data returns, the register slides its contents toward bit 0 by the access width and the new element takes the topmost lane. After enough loads the first element loaded sits in the lowest lane and the last one sits in the highest.

A write port replaces the whole register with any 64-bit value, which is how the starting contents are set. Only one load can be in flight at a time. While a load is outstanding the block deasserts its ready output, and a command offered then is neither read nor remembered. Each finished load raises a one-cycle done pulse, and the updated value is visible on the output during that pulse.

Top module: `load_align_acc`

## Requirements
- R1: While reset is asserted and right after it, `acc_o` is zero, `done_o` is 0, `cmd_ready` is 1 and `mem_rd_en` is 0 unless a command is offered.
- R2: A load with `cmd_size`=0 (byte) sets the register to {byte, old[63:8]}: the byte lands in bits 63:56, and old bits 63:8 move to bits 55:0.
- R3: A load with `cmd_size`=1 (halfword) sets the register to {halfword, old[63:16]}: the halfword lands in bits 63:48, and old bits 63:16 move to bits 47:0.
- R4: The halfword is little-endian. `mem_rd_data[7:0]` is the byte at the address and becomes bits 55:48. `mem_rd_data[15:8]` is the byte at address+1 and becomes bits 63:56. Odd addresses are allowed. A byte load uses `mem_rd_data[7:0]` only.
- R5: A command is accepted in a cycle where `cmd_valid` and `cmd_ready` are both 1. In that same cycle `mem_rd_en` is 1 and `mem_addr` equals `cmd_addr`. The memory returns data one clock later. The register and a one-cycle `done_o` pulse change one clock after that.
- R6: `cmd_ready` is 0 from the clock that accepts a load until the clock that completes it. A command offered while `cmd_ready` is 0 causes no memory read and no change to the register.
- R7: With `wr_en`=1, `acc_o` equals `wr_data` after the next clock.
- R8: If `wr_en` is 1 in the cycle a load completes, the write wins. The register takes `wr_data`, the load result is dropped, `done_o` stays 0 and the block becomes ready again.
- R9: Bits that the shift does not displace keep their values. Starting from all ones, byte loads of 01,02,03,04 give 0x04030201FFFFFFFF. Halfword loads at addresses 0,2,4,6 of memory holding 01..08 give 0x0807060504030201.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Load command offered |
| cmd_size | input | 1 | 0 = byte, 1 = halfword |
| cmd_addr | input | ADDR_W | Byte address of the load |
| cmd_ready | output | 1 | Block can accept a command |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rd_data | input | 2*LANE_W | Bytes at address (low) and address+1 (high), one clock after the strobe |
| wr_en | input | 1 | Overwrite the register |
| wr_data | input | DATA_W | Value written |
| acc_o | output | DATA_W | Register contents |
| done_o | output | 1 | One-cycle pulse when a load result is in `acc_o` |

## Verification
The hardest case to reach is a write landing in the exact cycle an outstanding load completes. The stimulus reaches it by offering a load and then driving `wr_en` one clock later, while the read data is on its way back. The bench then confirms that the written value is present, that no done pulse appeared and that ready has returned. A second hard case is a command held on the inputs while the block is busy. The bench changes the address during that cycle and checks that no read strobe appears, and that exactly one result with the first address arrives.

// File: rtl/la_pkg.sv
package la_pkg;
    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_HALF = 1'b1
    } la_size_e;
endpackage

// File: rtl/la_issue_ctrl.sv
module la_issue_ctrl
    import la_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  la_size_e          cmd_size_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    output logic              cmd_ready_o,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              complete_o,
    output la_size_e          size_o
);
    typedef struct packed {
        logic     pend;
        la_size_e size;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     issue;

    always_comb begin
        st_d  = st_q;
        issue = cmd_valid_i && !st_q.pend;
        // one outstanding read; it always returns the following cycle
        st_d.pend = issue;
        if (issue) begin
            st_d.size = cmd_size_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pend: 1'b0, size: SZ_BYTE};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_ready_o = !st_q.pend;
    assign mem_rd_en_o = issue;
    assign mem_addr_o  = cmd_addr_i;
    assign complete_o  = st_q.pend;
    assign size_o      = st_q.size;

    // R6
    single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> !mem_rd_en_o && complete_o);
endmodule

// File: rtl/la_lane_merge.sv
module la_lane_merge
    import la_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    localparam int RD_W  = 2 * LANE_W
) (
    input  logic [DATA_W-1:0] acc_i,
    input  logic [RD_W-1:0]   rd_data_i,
    input  la_size_e          size_i,
    output logic [DATA_W-1:0] merged_o
);
    localparam int NSZ = 2;

    logic [DATA_W-1:0] cand [NSZ];

    for (genvar s = 0; s < NSZ; s++) begin : g_sz
        localparam int W = LANE_W << s;
        // new element enters at the top, older contents slide down
        assign cand[s] = {rd_data_i[W-1:0], acc_i[DATA_W-1:W]};
    end

    always_comb begin
        merged_o = (size_i == SZ_HALF) ? cand[1] : cand[0];
    end
endmodule

// File: rtl/la_acc_reg.sv
module la_acc_reg
    import la_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              complete_i,
    input  la_size_e          size_i,
    input  logic [DATA_W-1:0] merged_i,
    output logic [DATA_W-1:0] acc_o,
    output logic              done_o
);
    localparam int HW = 2 * LANE_W;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              done;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (wr_en_i) begin
            st_d.acc = wr_data_i;
        end else if (complete_i) begin
            st_d.acc  = merged_i;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o  = st_q.acc;
    assign done_o = st_q.done;

    // R2
    byte_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (complete_i && !wr_en_i && size_i == SZ_BYTE) |=>
            acc_o[DATA_W-LANE_W-1:0] == $past(acc_o[DATA_W-1:LANE_W]));

    // R3
    half_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (complete_i && !wr_en_i && size_i == SZ_HALF) |=>
            acc_o[DATA_W-HW-1:0] == $past(acc_o[DATA_W-1:HW]));
endmodule

// File: rtl/load_align_acc.sv
module load_align_acc
    import la_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    parameter int ADDR_W = 16,
    localparam int RD_W  = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_size,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ready,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [RD_W-1:0]   mem_rd_data,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] acc_o,
    output logic              done_o
);
    logic              complete;
    la_size_e          pend_size;
    logic [DATA_W-1:0] merged;

    la_issue_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid),
        .cmd_size_i  (la_size_e'(cmd_size)),
        .cmd_addr_i  (cmd_addr),
        .cmd_ready_o (cmd_ready),
        .mem_rd_en_o (mem_rd_en),
        .mem_addr_o  (mem_addr),
        .complete_o  (complete),
        .size_o      (pend_size)
    );

    la_lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) merge_i (
        .acc_i     (acc_o),
        .rd_data_i (mem_rd_data),
        .size_i    (pend_size),
        .merged_o  (merged)
    );

    la_acc_reg #(.DATA_W(DATA_W), .LANE_W(LANE_W)) acc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .complete_i (complete),
        .size_i     (pend_size),
        .merged_i   (merged),
        .acc_o      (acc_o),
        .done_o     (done_o)
    );

    // R5
    done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(mem_rd_en, 2));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (acc_o == $past(wr_data)) && !done_o);

    // R6
    busy_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |-> !mem_rd_en);
endmodule

// File: tb/load_align_acc_tb_top.sv
module load_align_acc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_size = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic        cmd_ready;
    logic        mem_rd_en;
    logic [15:0] mem_addr;
    logic [15:0] mem_rd_data = '0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] acc_o;
    logic        done_o;

    int total = 0;
    int bad = 0;
    logic [63:0] model = '0;
    logic [63:0] exp_q[$];
    logic [7:0]  mem [256];

    always #4 clk = ~clk;

    load_align_acc dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_size(cmd_size),
        .cmd_addr(cmd_addr), .cmd_ready(cmd_ready), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .wr_en(wr_en),
        .wr_data(wr_data), .acc_o(acc_o), .done_o(done_o)
    );

    // synchronous read memory, little-endian pair
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= {mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=0x%016h exp=0x%016h", req, act, exp);
        end
    endtask

    // monitor: pops expected results on each done pulse
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5/R8 unexpected done", acc_o, model);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                chk(acc_o == e, "R2/R3 load result", acc_o, e);
            end
        end
    end

    task automatic do_load(input logic sz, input logic [15:0] a);
        logic [7:0] lo, hi;
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_size = sz; cmd_addr = a;
        #1;
        chk(mem_rd_en && mem_addr == a, "R5 read strobe and address", {47'd0, mem_rd_en, mem_addr}, {47'd0, 1'b1, a});
        lo = mem[a[7:0]];
        hi = mem[8'(a[7:0] + 8'd1)];
        model = sz ? {hi, lo, model[63:16]} : {lo, model[63:8]};
        exp_q.push_back(model);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!cmd_ready, "R6 busy while outstanding", {63'd0, cmd_ready}, 64'd0);
        chk(!done_o, "R5 no early done", {63'd0, done_o}, 64'd0);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [63:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        chk(acc_o == v, "R7 write", acc_o, v);
        model = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 64'd0, 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = (i < 16) ? 8'(i + 1) : 8'((i * 7 + 3) & 255);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(acc_o == 64'd0 && !done_o, "R1 reset value", acc_o, 64'd0);
        chk(cmd_ready && !mem_rd_en, "R1 ready, no read", {62'd0, cmd_ready, mem_rd_en}, 64'd2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(acc_o == 64'd0 && cmd_ready && !done_o, "R1 after release", acc_o, 64'd0);

        // R9 byte sequence from all ones
        do_write('1);
        for (int i = 0; i < 4; i++) do_load(1'b0, 16'(i));
        chk(acc_o == 64'h04030201FFFFFFFF, "R9 byte sequence", acc_o, 64'h04030201FFFFFFFF);

        // R9 halfword sequence fills register
        do_write('1);
        for (int i = 0; i < 4; i++) do_load(1'b1, 16'(2 * i));
        chk(acc_o == 64'h0807060504030201, "R9 halfword sequence", acc_o, 64'h0807060504030201);

        // R4 odd-address halfword, little-endian
        do_write(64'h0123456789ABCDEF);
        do_load(1'b1, 16'd5);
        chk(acc_o[63:48] == 16'h0706, "R4 halfword byte order", {48'd0, acc_o[63:48]}, 64'h0706);
        chk(acc_o[47:0] == 48'h0123456789AB, "R3 lower bits shifted", {16'd0, acc_o[47:0]}, 64'h0123456789AB);

        // R2 byte from high address uses low data lane only
        do_load(1'b0, 16'd200);
        chk(acc_o[63:56] == mem[200], "R2 byte lane", {56'd0, acc_o[63:56]}, {56'd0, mem[200]});

        // mixed sizes
        do_load(1'b1, 16'd31);
        do_load(1'b0, 16'd7);
        do_load(1'b1, 16'd100);

        // R6 command held while busy is ignored
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_size = 1'b0; cmd_addr = 16'd10;
        model = {mem[10], model[63:8]};
        exp_q.push_back(model);
        @(negedge clk);
        cmd_addr = 16'd11;
        #1;
        chk(!mem_rd_en, "R6 no read while busy", {63'd0, mem_rd_en}, 64'd0);
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(acc_o == model, "R6 busy command had no effect", acc_o, model);

        // R8 write collides with completing load
        cmd_valid = 1'b1; cmd_size = 1'b1; cmd_addr = 16'd3;
        @(negedge clk);
        cmd_valid = 1'b0;
        wr_en = 1'b1; wr_data = 64'hDEADBEEFCAFEF00D;
        @(negedge clk);
        wr_en = 1'b0;
        chk(acc_o == 64'hDEADBEEFCAFEF00D, "R8 write wins", acc_o, 64'hDEADBEEFCAFEF00D);
        chk(!done_o && cmd_ready, "R8 no done, ready again", {62'd0, done_o, cmd_ready}, 64'd1);
        model = 64'hDEADBEEFCAFEF00D;

        // load continues from the written value
        do_load(1'b0, 16'd0);
        chk(acc_o == 64'h01DEADBEEFCAFEF0, "R2 after write", acc_o, 64'h01DEADBEEFCAFEF0);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all results seen", 64'(exp_q.size()), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule